// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block is the slave-side serial front end of a paged flash memory model. It oversamples the serial clock, chip select and data input with the system clock. At every chip-select falling edge it records the idle level of the serial clock as the clock mode. It then shifts in an 8-bit opcode and, depending on that opcode, a 24-bit address field and a run of don't-care bits. It presents the decoded command, the buffer select, the page address and the byte or buffer address, with a single-cycle strobe when the address field is complete.

For read-type commands the block enters an output phase once the header is finished. It asks an external byte source for data with a request pulse and shifts each byte out most significant bit first, changing the output only on serial clock falling edges. The output enable is low whenever chip select is high. Unknown opcodes and frames cut short before the address completes are reported with their own strobes. The memory array, the data buffers and program or erase timing are outside the block.

Top module: `sflash_frame_decoder`

## Requirements
- R1: After the synchronous reset `so_oe_o` is 0, `mode3_o` is 1, `cmd_o` is 0 and every strobe output is 0.
- R2: `mode3_o` takes the serial clock level seen when chip select falls (1 = idle high) and keeps it until the next chip-select falling edge.
- R3: Input bits are taken on serial clock rising edges, MSB first. For main-memory layouts the 24-bit field after the opcode carries the page address in field bits 18..9 and the byte address in bits 8..0; `cmd_vld_o` pulses once after the 24th field bit.
- R4: For buffer read and buffer write, field bits 8..0 give `byte_o` and `page_o` reads 0. `buf2_o` is 1 for opcodes 56h, D6h, 87h, 86h, 89h, 85h, 55h, 61h and 59h, and 0 for the other valid opcodes.
- R5: For block erase (50h), `page_o` is field bits 18..12 followed by three zero bits, and `byte_o` is 0.
- R6: Array read (68h/E8h) and page read (52h/D2h) wait for 32 don't-care bits after the field, and buffer read (54h/56h/D4h/D6h) waits for 8. The first output bit appears on the first falling edge after the last don't-care bit, and `out_start_o` pulses once per read frame.
- R7: Status read (57h/D7h) has no field. `cmd_vld_o` pulses after the 8th opcode bit, and output starts on the next falling edge.
- R8: Output bytes come from `tx_byte_i`, MSB first. `tx_req_o` pulses at the start of the output phase and after the last bit of each byte, and the byte present after a request is the next one sent.
- R9: After chip select rises, `so_oe_o` is 0 and stays 0 until a new output phase begins.
- R10: An opcode outside the command set pulses `invalid_o`, sets `cmd_o` to 0, and produces no `cmd_vld_o` and no output for the rest of the frame.
- R11: If chip select rises before the opcode and its field are complete, `abort_o` pulses, `cmd_vld_o` does not, and `page_o` keeps its previous value.
- R12: `cmd_o` codes are: 1 array read, 2 page read, 3 buffer read, 4 status, 5 buffer write, 6 program with erase (83h/86h), 7 program without erase (88h/89h), 8 page erase (81h), 9 block erase, 10 program through buffer (82h/85h), 11 page to buffer transfer (53h/55h), 12 compare (60h/61h), 13 rewrite (58h/59h). Non-read commands never enable the output.
- R13: Serial clock activity while chip select is high produces no strobe and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock |
| csn_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data input |
| tx_byte_i | input | 8 | Next byte to shift out |
| so_o | output | 1 | Serial data output |
| so_oe_o | output | 1 | Output enable for the serial data pin |
| tx_req_o | output | 1 | Pulse asking for the next output byte |
| mode3_o | output | 1 | Serial clock idle level captured at frame start |
| cmd_o | output | 4 | Decoded command code |
| buf2_o | output | 1 | Second buffer selected |
| page_o | output | 10 | Page address |
| byte_o | output | 9 | Byte or buffer address |
| cmd_vld_o | output | 1 | Header complete strobe |
| out_start_o | output | 1 | Output phase start strobe |
| invalid_o | output | 1 | Unknown opcode strobe |
| abort_o | output | 1 | Frame ended before header completed |

## Verification
A bit counter that is off by one shows as shifted page or byte fields at the `cmd_vld_o` strobe, or as a data bit missing or repeated on the first falling edge of the output phase. The bench catches this within half a serial clock period. A wrong phase state shows in `so_oe_o`, which the bench compares against its model on every settled clock. A wrong request pulse shows as an output byte from the wrong position of the source sequence. Strobe counts per frame expose decode or abort mistakes as soon as chip select rises.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  parameter int SFD_OPC_W       = 8;
  parameter int SFD_LONG_DUMMY  = 32;
  parameter int SFD_SHORT_DUMMY = 8;
  parameter int SFD_DUMMY_W     = $clog2(SFD_LONG_DUMMY) + 1;

  typedef enum logic [3:0] {
    CMD_NONE     = 4'd0,
    CMD_ARRAY_RD = 4'd1,
    CMD_PAGE_RD  = 4'd2,
    CMD_BUF_RD   = 4'd3,
    CMD_STATUS   = 4'd4,
    CMD_BUF_WR   = 4'd5,
    CMD_PROG_ER  = 4'd6,
    CMD_PROG_NE  = 4'd7,
    CMD_PAGE_ER  = 4'd8,
    CMD_BLOCK_ER = 4'd9,
    CMD_PROG_TB  = 4'd10,
    CMD_XFER     = 4'd11,
    CMD_COMPARE  = 4'd12,
    CMD_REWRITE  = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    LAY_NONE = 2'd0,
    LAY_MAIN = 2'd1,
    LAY_BUF  = 2'd2,
    LAY_BLK  = 2'd3
  } lay_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_SKIP
  } st_e;

  typedef struct packed {
    logic                   ok;
    cmd_e                   cmd;
    lay_e                   lay;
    logic [SFD_DUMMY_W-1:0] dummy;
    logic                   rd;
    logic                   buf2;
  } dec_t;

  function automatic dec_t sfd_decode(input logic [SFD_OPC_W-1:0] op);
    dec_t d;
    d.ok    = 1'b1;
    d.cmd   = CMD_NONE;
    d.lay   = LAY_MAIN;
    d.dummy = '0;
    d.rd    = 1'b0;
    d.buf2  = 1'b0;
    case (op)
      8'h68, 8'hE8: begin
        d.cmd = CMD_ARRAY_RD; d.rd = 1'b1;
        d.dummy = SFD_DUMMY_W'(SFD_LONG_DUMMY);
      end
      8'h52, 8'hD2: begin
        d.cmd = CMD_PAGE_RD; d.rd = 1'b1;
        d.dummy = SFD_DUMMY_W'(SFD_LONG_DUMMY);
      end
      8'h54, 8'hD4, 8'h56, 8'hD6: begin
        d.cmd = CMD_BUF_RD; d.rd = 1'b1; d.lay = LAY_BUF;
        d.dummy = SFD_DUMMY_W'(SFD_SHORT_DUMMY); d.buf2 = op[1];
      end
      8'h57, 8'hD7: begin
        d.cmd = CMD_STATUS; d.rd = 1'b1; d.lay = LAY_NONE;
      end
      8'h84, 8'h87: begin
        d.cmd = CMD_BUF_WR; d.lay = LAY_BUF; d.buf2 = op[0];
      end
      8'h83, 8'h86: begin d.cmd = CMD_PROG_ER; d.buf2 = (op == 8'h86); end
      8'h88, 8'h89: begin d.cmd = CMD_PROG_NE; d.buf2 = op[0]; end
      8'h81:        d.cmd = CMD_PAGE_ER;
      8'h50:        begin d.cmd = CMD_BLOCK_ER; d.lay = LAY_BLK; end
      8'h82, 8'h85: begin d.cmd = CMD_PROG_TB; d.buf2 = (op == 8'h85); end
      8'h53, 8'h55: begin d.cmd = CMD_XFER; d.buf2 = (op == 8'h55); end
      8'h60, 8'h61: begin d.cmd = CMD_COMPARE; d.buf2 = op[0]; end
      8'h58, 8'h59: begin d.cmd = CMD_REWRITE; d.buf2 = op[0]; end
      default:      d.ok = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sfd_pin_sync.sv
module sfd_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sck_lvl_o,
  output logic csn_lvl_o,
  output logic si_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o
);
  logic sck_q, csn_q, si_q, sck_d, csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b1;
      csn_q <= 1'b1;
      si_q  <= 1'b0;
      sck_d <= 1'b1;
      csn_d <= 1'b1;
    end else begin
      sck_q <= sck_i;
      csn_q <= csn_i;
      si_q  <= si_i;
      sck_d <= sck_q;
      csn_d <= csn_q;
    end
  end

  assign sck_lvl_o  = sck_q;
  assign csn_lvl_o  = csn_q;
  assign si_o       = si_q;
  assign sck_rise_o = sck_q & ~sck_d;
  assign sck_fall_o = ~sck_q & sck_d;
  assign cs_fall_o  = ~csn_q & csn_d;
  assign cs_rise_o  = csn_q & ~csn_d;
endmodule

// File: rtl/sfd_hdr_fsm.sv
module sfd_hdr_fsm
  import sfd_pkg::*;
#(
  parameter int RSV_W  = 5,
  parameter int PAGE_W = 10,
  parameter int BYTE_W = 9,
  parameter int BLK_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_lvl_i,
  input  logic              si_i,
  input  logic              sck_rise_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  output logic              mode3_o,
  output logic [3:0]        cmd_o,
  output logic              buf2_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o,
  output logic              start_o,
  output logic              invalid_o,
  output logic              abort_o,
  output logic              rd_act_o
);
  localparam int ADDR_W = RSV_W + PAGE_W + BYTE_W;
  localparam int MAXB   = (ADDR_W > SFD_LONG_DUMMY) ? ADDR_W : SFD_LONG_DUMMY;
  localparam int CNT_W  = $clog2(MAXB) + 1;
  localparam int BLK_HI = ADDR_W - RSV_W - 1;

  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;
  dec_t              cur;
  dec_t              dec_now;
  logic [SFD_OPC_W-1:0] opc_now;
  logic [ADDR_W-1:0] addr_now;

  always_comb begin
    opc_now  = {sh[SFD_OPC_W-2:0], si_i};
    addr_now = {sh[ADDR_W-2:0], si_i};
    dec_now  = sfd_decode(opc_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; cur <= '0;
      mode3_o <= 1'b1; cmd_o <= CMD_NONE; buf2_o <= 1'b0;
      page_o <= '0; byte_o <= '0;
      vld_o <= 1'b0; start_o <= 1'b0; invalid_o <= 1'b0; abort_o <= 1'b0;
      rd_act_o <= 1'b0;
    end else begin
      vld_o <= 1'b0; start_o <= 1'b0; invalid_o <= 1'b0; abort_o <= 1'b0;
      if (cs_rise_i) begin
        if (st == ST_OPC || st == ST_ADDR) abort_o <= 1'b1;
        st <= ST_IDLE;
        rd_act_o <= 1'b0;
      end else if (cs_fall_i) begin
        st <= ST_OPC;
        cnt <= '0;
        mode3_o <= sck_lvl_i;
        rd_act_o <= 1'b0;
      end else if (sck_rise_i && st != ST_IDLE) begin
        sh  <= addr_now;
        cnt <= cnt + 1'b1;
        case (st)
          ST_OPC: if (cnt == CNT_W'(SFD_OPC_W - 1)) begin
            cnt    <= '0;
            cur    <= dec_now;
            buf2_o <= dec_now.buf2;
            cmd_o  <= dec_now.ok ? dec_now.cmd : CMD_NONE;
            if (!dec_now.ok) begin
              invalid_o <= 1'b1;
              st <= ST_SKIP;
            end else if (dec_now.lay == LAY_NONE) begin
              vld_o <= 1'b1; start_o <= 1'b1; rd_act_o <= 1'b1;
              st <= ST_DATA;
            end else begin
              st <= ST_ADDR;
            end
          end
          ST_ADDR: if (cnt == CNT_W'(ADDR_W - 1)) begin
            cnt   <= '0;
            vld_o <= 1'b1;
            case (cur.lay)
              LAY_BUF: begin
                page_o <= '0;
                byte_o <= addr_now[BYTE_W-1:0];
              end
              LAY_BLK: begin
                page_o <= {addr_now[BLK_HI -: BLK_W], {(PAGE_W-BLK_W){1'b0}}};
                byte_o <= '0;
              end
              default: begin
                page_o <= addr_now[BYTE_W +: PAGE_W];
                byte_o <= addr_now[BYTE_W-1:0];
              end
            endcase
            if (cur.dummy != '0) begin
              st <= ST_DUMMY;
            end else begin
              st <= ST_DATA;
              rd_act_o <= cur.rd;
              start_o  <= cur.rd;
            end
          end
          ST_DUMMY: if (cnt == CNT_W'(cur.dummy - 1'b1)) begin
            st <= ST_DATA; rd_act_o <= 1'b1; start_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the captured clock mode changes only at a chip-select falling edge
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cs_fall_i |=> $stable(mode3_o));
  // R10: a frame with an unknown opcode never enables the output phase
  p_skip_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !rd_act_o);
endmodule

// File: rtl/sfd_tx_shift.sv
module sfd_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              stop_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              so_o,
  output logic              oe_o,
  output logic              req_o
);
  localparam int BC_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [BC_W-1:0]   bitc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; bitc <= '0; so_o <= 1'b0; oe_o <= 1'b0; req_o <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (!active_i || stop_i) begin
        oe_o <= 1'b0;
        bitc <= '0;
      end else if (fall_i) begin
        oe_o <= 1'b1;
        bitc <= bitc + 1'b1;
        if (bitc == '0) begin
          so_o <= byte_i[DATA_W-1];
          sh   <= {byte_i[DATA_W-2:0], 1'b0};
        end else begin
          so_o <= sh[DATA_W-1];
          sh   <= {sh[DATA_W-2:0], 1'b0};
        end
        if (bitc == BC_W'(DATA_W - 1)) req_o <= 1'b1;
      end
    end
  end

  // R8: while driving, the data bit only moves after a serial clock falling edge
  p_so_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (oe_o && $past(oe_o) && !$past(fall_i)) |-> $stable(so_o));
endmodule

// File: rtl/sflash_frame_decoder.sv
module sflash_frame_decoder
  import sfd_pkg::*;
#(
  parameter int RSV_W  = 5,
  parameter int PAGE_W = 10,
  parameter int BYTE_W = 9,
  parameter int BLK_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              si_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              tx_req_o,
  output logic              mode3_o,
  output logic [3:0]        cmd_o,
  output logic              buf2_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              cmd_vld_o,
  output logic              out_start_o,
  output logic              invalid_o,
  output logic              abort_o
);
  logic sck_lvl, csn_lvl, si_s, sck_rise, sck_fall, cs_fall, cs_rise;
  logic rd_act, byte_req;

  sfd_pin_sync sync_i (
    .clk(clk), .rst(rst), .sck_i(sck_i), .csn_i(csn_i), .si_i(si_i),
    .sck_lvl_o(sck_lvl), .csn_lvl_o(csn_lvl), .si_o(si_s),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise)
  );

  sfd_hdr_fsm #(
    .RSV_W(RSV_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .BLK_W(BLK_W)
  ) hdr_i (
    .clk(clk), .rst(rst), .sck_lvl_i(sck_lvl), .si_i(si_s),
    .sck_rise_i(sck_rise), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .mode3_o(mode3_o), .cmd_o(cmd_o), .buf2_o(buf2_o),
    .page_o(page_o), .byte_o(byte_o), .vld_o(cmd_vld_o),
    .start_o(out_start_o), .invalid_o(invalid_o), .abort_o(abort_o),
    .rd_act_o(rd_act)
  );

  sfd_tx_shift #(.DATA_W(DATA_W)) tx_i (
    .clk(clk), .rst(rst), .active_i(rd_act), .stop_i(cs_rise),
    .fall_i(sck_fall), .byte_i(tx_byte_i),
    .so_o(so_o), .oe_o(so_oe_o), .req_o(byte_req)
  );

  assign tx_req_o = out_start_o | byte_req;

  // R9: with chip select high for two samples the output is released
  p_oe_cs_r9: assert property (@(posedge clk) disable iff (rst)
    (csn_lvl && $past(csn_lvl)) |-> !so_oe_o);
  // R11: header strobe, abort and invalid never coincide
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_vld_o, abort_o, invalid_o}));
  // R13: no strobe comes out while chip select is high
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    (csn_lvl && $past(csn_lvl)) |-> !(cmd_vld_o || out_start_o || invalid_o));
endmodule

// File: tb/sflash_frame_decoder_tb_top.sv
module sflash_frame_decoder_tb_top;
  localparam int CLK_P = 10;
  localparam int H     = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sck_i = 1'b0, csn_i = 1'b1, si_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic so_o, so_oe_o, tx_req_o, mode3_o, buf2_o;
  logic [3:0] cmd_o;
  logic [9:0] page_o;
  logic [8:0] byte_o;
  logic cmd_vld_o, out_start_o, invalid_o, abort_o;

  always #(CLK_P/2) clk = ~clk;

  sflash_frame_decoder dut_i (
    .clk(clk), .rst(rst), .sck_i(sck_i), .csn_i(csn_i), .si_i(si_i),
    .tx_byte_i(tx_byte_i), .so_o(so_o), .so_oe_o(so_oe_o),
    .tx_req_o(tx_req_o), .mode3_o(mode3_o), .cmd_o(cmd_o), .buf2_o(buf2_o),
    .page_o(page_o), .byte_o(byte_o), .cmd_vld_o(cmd_vld_o),
    .out_start_o(out_start_o), .invalid_o(invalid_o), .abort_o(abort_o)
  );

  int checks = 0, fails = 0, quiet = 0;
  int n_vld, n_abort, n_inv, n_start, tx_idx, ob_idx, obit;
  logic out_phase = 1'b0, exp_oe = 1'b0, exp_so = 1'b0, done = 1'b0;
  logic [7:0] ocur;

  function automatic logic [7:0] src(input int k);
    return 8'hA5 ^ 8'(k * 37);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: settled levels compared on every clock, strobes counted
  always @(negedge clk) begin
    if (!rst && !done) begin
      quiet++;
      if (cmd_vld_o)   n_vld++;
      if (abort_o)     n_abort++;
      if (invalid_o)   n_inv++;
      if (out_start_o) n_start++;
      if (tx_req_o) begin tx_byte_i <= src(tx_idx); tx_idx++; end
      if (quiet >= 3) begin
        chk("R9/R12 so_oe level", so_oe_o, exp_oe);
        if (exp_oe) chk("R8 so level", so_o, exp_so);
      end
    end
  end

  task automatic model_fall();
    if (obit == 0) begin ocur = src(ob_idx); ob_idx++; end
    exp_so = ocur[7 - obit];
    obit = (obit + 1) % 8;
    exp_oe = 1'b1;
  endtask

  task automatic set_sck(input logic v, input logic d);
    @(posedge clk); #1;
    if (sck_i && !v && out_phase) model_fall();
    sck_i = v; si_i = d; quiet = 0;
    repeat (H-1) @(posedge clk);
    #2;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n-1; i >= 0; i--) begin
      set_sck(1'b0, v[i]);
      set_sck(1'b1, v[i]);
    end
  endtask

  task automatic read_bytes(input int n, input string tag);
    out_phase = 1'b1;
    for (int b = 0; b < n; b++) begin
      logic [7:0] got;
      for (int i = 7; i >= 0; i--) begin
        set_sck(1'b0, 1'b0);
        got[i] = so_o;
        set_sck(1'b1, 1'b0);
      end
      chk(tag, got, src(b));
    end
  endtask

  task automatic cs_low(input logic idle);
    set_sck(idle, 1'b0);
    n_vld = 0; n_abort = 0; n_inv = 0; n_start = 0;
    tx_idx = 0; ob_idx = 0; obit = 0;
    @(posedge clk); #1;
    csn_i = 1'b0; quiet = 0;
    repeat (2*H) @(posedge clk);
    #2;
  endtask

  task automatic cs_high(input logic mode0);
    if (mode0) set_sck(1'b0, 1'b0);
    @(posedge clk); #1;
    csn_i = 1'b1; quiet = 0; out_phase = 1'b0; exp_oe = 1'b0;
    repeat (2*H) @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 so_oe", so_oe_o, 0); chk("R1 mode3", mode3_o, 1);
    chk("R1 cmd", cmd_o, 0);
    chk("R1 strobes", {cmd_vld_o, out_start_o, invalid_o, abort_o, tx_req_o}, 0);

    // R3 R6 R2: array read, mode 0
    cs_low(1'b0);
    chk("R2 mode0 captured", mode3_o, 0);
    send(32'h68, 8); send({5'h1F, 10'h2AB, 9'h155}, 24); send(32'hFFFF_FFFF, 32);
    chk("R3 page", page_o, 10'h2AB); chk("R3 byte", byte_o, 9'h155);
    chk("R12 cmd array", cmd_o, 1); chk("R3 vld once", n_vld, 1);
    chk("R6 no output during dummy", so_oe_o, 0);
    read_bytes(3, "R6/R8 array byte");
    chk("R6 start once", n_start, 1);
    cs_high(1'b1);
    chk("R9 oe after cs", so_oe_o, 0);

    // R4 R6: buffer 2 read, mode 3
    cs_low(1'b1);
    chk("R2 mode3 captured", mode3_o, 1);
    send(32'hD6, 8); send({15'h7FFF, 9'h107}, 24); send(32'h0, 8);
    chk("R4 page zero", page_o, 0); chk("R4 byte", byte_o, 9'h107);
    chk("R4 buf2", buf2_o, 1); chk("R12 cmd bufrd", cmd_o, 3);
    read_bytes(2, "R6/R8 buffer byte");
    cs_high(1'b0);

    // R7: status read, mode 3
    cs_low(1'b1);
    send(32'hD7, 8);
    chk("R7 vld after opcode", n_vld, 1); chk("R12 cmd status", cmd_o, 4);
    read_bytes(2, "R7 status byte");
    chk("R7 start", n_start, 1);
    cs_high(1'b0);

    // R5: block erase, no output
    cs_low(1'b0);
    send(32'h50, 8); send({5'h1F, 7'h55, 12'hABC}, 24);
    chk("R5 page", page_o, 10'h2A8); chk("R5 byte", byte_o, 0);
    chk("R12 cmd blk", cmd_o, 9); chk("R4 buf2 low", buf2_o, 0);
    send(32'hFFFF, 16);
    chk("R12 erase no oe", so_oe_o, 0);
    cs_high(1'b1);
    chk("R12 erase no start", n_start, 0);

    // R4 R12: buffer 2 write with data
    cs_low(1'b1);
    send(32'h87, 8); send({15'h1234, 9'h0AA}, 24);
    chk("R4 wr byte", byte_o, 9'h0AA); chk("R4 wr buf2", buf2_o, 1);
    chk("R12 cmd bufwr", cmd_o, 5);
    send(32'h5A, 8);
    chk("R12 write no oe", so_oe_o, 0);
    cs_high(1'b0);

    // R3 R12: program with erase, mode 0
    cs_low(1'b0);
    send(32'h83, 8); send({5'h0, 10'h001, 9'h1FF}, 24);
    chk("R12 cmd prog", cmd_o, 6); chk("R3 page prog", page_o, 10'h001);
    chk("R3 byte prog", byte_o, 9'h1FF); chk("R4 buf2 prog", buf2_o, 0);
    cs_high(1'b1);

    // R10: unknown opcode
    cs_low(1'b1);
    send(32'hFF, 8);
    chk("R10 invalid", n_inv, 1); chk("R10 cmd none", cmd_o, 0);
    send(32'h0000_A5A5, 16);
    chk("R10 no oe", so_oe_o, 0);
    cs_high(1'b0);
    chk("R10 no vld", n_vld, 0); chk("R10 no start", n_start, 0);

    // R11: abort inside address field
    cs_low(1'b0);
    send(32'h52, 8); send(32'h3FF, 10);
    cs_high(1'b1);
    chk("R11 abort", n_abort, 1); chk("R11 no vld", n_vld, 0);
    chk("R11 page kept", page_o, 10'h001);

    // R13: clocking with chip select high
    n_vld = 0; n_abort = 0; n_inv = 0; n_start = 0;
    send(32'hFFFF, 16);
    chk("R13 no strobes", n_vld + n_abort + n_inv + n_start, 0);
    chk("R13 no oe", so_oe_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule